// File: doc/BRIEF.md
# Toggle-Bit Event Queue Reader

This block drains a circular event queue of 32-bit words held in a small local RAM. A producer port appends 31-bit payloads in order. The block marks each stored word with a generation bit in bit 31. The reader side has one read index and one toggle bit. A word counts as fresh when its generation bit differs from the toggle. Because of this, emptiness is decided by the word under the read index. There is no head/tail pointer comparison, so the reader never has to see the producer's position.

A client issues single-cycle requests. Each request is either a consume, which takes the word and moves on, or a peek, which only looks. One clock later the block answers with a valid strobe and either the 31-bit payload or zero, meaning nothing new. When the queue is switched off, every answer is zero and nothing moves. The depth is a power-of-two parameter. The index wraps with a mask of depth minus one, and the toggle inverts each time the index wraps to zero. A payload of zero is reserved as the empty code, and producers must never write it.

Top module: `evq_reader_top`

## Requirements
- R1: After reset the read index is 0, the toggle is 0, every RAM word is 0 and `rsp_valid` is low, so the first request returns zero.
- R2: The word at the read index is new only when `q_enable` is high and its bit 31 differs from the toggle. Otherwise the response data is zero and the index and toggle stay unchanged.
- R3: For a new word, `rsp_data` equals bits 30:0 of the stored word, with the generation bit removed.
- R4: A consume of a new word advances the read index by one modulo DEPTH.
- R5: When a consume brings the index back to 0, the toggle inverts. Words left over from the previous lap then read as empty.
- R6: A peek (`req_peek`=1) returns the same data a consume would return, but leaves the index and toggle unchanged.
- R7: While `q_enable` is low, every response carries zero data and the reader state does not change, even if fresh words are stored.
- R8: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high, and is low otherwise.
- R9: Each `wr_valid` pulse stores {generation, `wr_payload`} at the producer's own index, which starts at 0 and increments modulo DEPTH. The generation starts at 1 and inverts each time the producer index wraps to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| q_enable | input | 1 | Queue configured; when low all reads return zero |
| wr_valid | input | 1 | Producer write strobe |
| wr_payload | input | 31 | Producer payload, nonzero |
| req_valid | input | 1 | Read request strobe |
| req_peek | input | 1 | 1 = peek, 0 = consume |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_data | output | 31 | Payload, or zero when nothing is new |

## Verification
The hardest case to reach from the ports is a stale word from the previous lap. After the reader wraps and the toggle inverts, such a word must read as empty even though its content is nonzero. The stimulus gets there in two ways. It interleaves more than two full laps of writes and consumes, and it also fills an entire lap before draining it. After each drain the reader ends up on slots whose data was written one generation earlier. Peeks and disabled reads are mixed in while fresh words are pending. This shows that neither kind of request moves the reader.

// File: rtl/evq_pkg.sv
package evq_pkg;
    localparam int PAYLOAD_W = 31;

    typedef struct packed {
        logic                 gen;
        logic [PAYLOAD_W-1:0] payload;
    } evq_word_t;
endpackage

// File: rtl/evq_ram.sv
module evq_ram
    import evq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  evq_word_t        wdata,
    input  logic [IDX_W-1:0] raddr,
    output evq_word_t        rdata
);
    evq_word_t mem_q [DEPTH];
    evq_word_t mem_d [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_comb begin
            mem_d[g] = mem_q[g];
            if (we && (waddr == IDX_W'(g))) begin
                mem_d[g] = wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else begin
                mem_q[g] <= mem_d[g];
            end
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/evq_writer.sv
module evq_writer
    import evq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_valid,
    input  logic [PAYLOAD_W-1:0] wr_payload,
    output logic                 we,
    output logic [IDX_W-1:0]     waddr,
    output evq_word_t            wdata
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             gen;
    } wr_state_t;

    wr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_valid) begin
            st_d.idx = st_q.idx + 1'b1;
            if (st_d.idx == '0) begin
                st_d.gen = ~st_q.gen;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.idx <= '0;
            st_q.gen <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign we            = wr_valid;
    assign waddr         = st_q.idx;
    assign wdata.gen     = st_q.gen;
    assign wdata.payload = wr_payload;
endmodule

// File: rtl/evq_reader.sv
module evq_reader
    import evq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 q_enable,
    input  logic                 req_valid,
    input  logic                 req_peek,
    input  evq_word_t            rd_word,
    output logic [IDX_W-1:0]     rd_addr,
    output logic                 rd_tog,
    output logic                 rsp_valid,
    output logic [PAYLOAD_W-1:0] rsp_data
);
    typedef struct packed {
        logic [IDX_W-1:0]     idx;
        logic                 tog;
        logic                 rsp_valid;
        logic [PAYLOAD_W-1:0] rsp_data;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic      is_new;

    always_comb begin
        st_d           = st_q;
        is_new         = q_enable && (rd_word.gen != st_q.tog);
        st_d.rsp_valid = req_valid;
        st_d.rsp_data  = '0;
        if (req_valid && is_new) begin
            st_d.rsp_data = rd_word.payload;
            if (!req_peek) begin
                st_d.idx = st_q.idx + 1'b1;
                if (st_d.idx == '0) begin
                    st_d.tog = ~st_q.tog;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_addr   = st_q.idx;
    assign rd_tog    = st_q.tog;
    assign rsp_valid = st_q.rsp_valid;
    assign rsp_data  = st_q.rsp_data;
endmodule

// File: rtl/evq_reader_top.sv
module evq_reader_top
    import evq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 q_enable,
    input  logic                 wr_valid,
    input  logic [PAYLOAD_W-1:0] wr_payload,
    input  logic                 req_valid,
    input  logic                 req_peek,
    output logic                 rsp_valid,
    output logic [PAYLOAD_W-1:0] rsp_data
);
    localparam int IDX_W = $clog2(DEPTH);

    logic             ram_we;
    logic [IDX_W-1:0] ram_waddr;
    evq_word_t        ram_wdata;
    logic [IDX_W-1:0] rd_idx;
    logic             rd_tog;
    evq_word_t        ram_rdata;

    evq_writer #(.DEPTH(DEPTH)) writer_i (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_payload(wr_payload),
        .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata)
    );

    evq_ram #(.DEPTH(DEPTH)) ram_i (
        .clk(clk), .rst_n(rst_n), .we(ram_we), .waddr(ram_waddr),
        .wdata(ram_wdata), .raddr(rd_idx), .rdata(ram_rdata)
    );

    evq_reader #(.DEPTH(DEPTH)) reader_i (
        .clk(clk), .rst_n(rst_n), .q_enable(q_enable), .req_valid(req_valid),
        .req_peek(req_peek), .rd_word(ram_rdata), .rd_addr(rd_idx),
        .rd_tog(rd_tog), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );
endmodule

// File: rtl/evq_reader_chk.sv
module evq_reader_chk #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             q_enable,
    input logic             req_valid,
    input logic             req_peek,
    input logic             rsp_valid,
    input logic [30:0]      rsp_data,
    input logic [IDX_W-1:0] rd_idx,
    input logic             rd_tog
);
    localparam logic [IDX_W-1:0] STEP = 1;

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R8
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R8
    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !q_enable) |=> (rsp_data == '0)); // R7
    AST_PEEK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_peek) |=> ($stable(rd_idx) && $stable(rd_tog))); // R6
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_idx) |-> (rd_idx == $past(rd_idx) + STEP)); // R4
    AST_TOG_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_tog) |-> (rd_idx == '0)); // R5
    AST_EMPTY_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_data == '0) |-> $stable(rd_idx)); // R2
endmodule

bind evq_reader_top evq_reader_chk #(.DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .q_enable(q_enable), .req_valid(req_valid),
    .req_peek(req_peek), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rd_idx(rd_idx), .rd_tog(rd_tog)
);

// File: tb/evq_reader_tb.sv
module evq_reader_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        q_enable = 1;
    logic        wr_valid = 0;
    logic [30:0] wr_payload = '0;
    logic        req_valid = 0;
    logic        req_peek = 0;
    logic        rsp_valid;
    logic [30:0] rsp_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [30:0] exp_q[$];
    string       tag_q[$];
    logic        prev_req = 0;

    logic        m_gen [DEPTH];
    logic [30:0] m_pay [DEPTH];
    int          w_idx = 0;
    logic        w_gen = 1;
    int          r_idx = 0;
    logic        r_tog = 0;

    evq_reader_top #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .q_enable(q_enable), .wr_valid(wr_valid),
        .wr_payload(wr_payload), .req_valid(req_valid), .req_peek(req_peek),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) prev_req <= rst_n && req_valid;

    // Monitor: compare responses away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (rsp_valid !== prev_req) begin
                errors++;
                $display("FAIL R8 rsp_valid actual %0b expected %0b", rsp_valid, prev_req);
            end
            if (rsp_valid === 1'b1 && exp_q.size() > 0) begin
                logic [30:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (rsp_data !== e) begin
                    errors++;
                    $display("FAIL %s rsp_data actual %h expected %h", t, rsp_data, e);
                end
            end
        end
    end

    task automatic drv_write(input logic [30:0] p);
        wr_valid   = 1;
        wr_payload = p;
        m_gen[w_idx] = w_gen;
        m_pay[w_idx] = p;
        w_idx = (w_idx + 1) % DEPTH;
        if (w_idx == 0) w_gen = ~w_gen;
        @(posedge clk); #1;
        wr_valid = 0;
    endtask

    task automatic drv_req(input logic peek, input string tag);
        logic [30:0] e;
        e = '0;
        if (q_enable && (m_gen[r_idx] != r_tog)) begin
            e = m_pay[r_idx];
            if (!peek) begin
                r_idx = (r_idx + 1) % DEPTH;
                if (r_idx == 0) r_tog = ~r_tog;
            end
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        req_valid = 1;
        req_peek  = peek;
        @(posedge clk); #1;
        req_valid = 0;
        req_peek  = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_gen[i] = 0;
            m_pay[i] = '0;
        end
        idle(3);
        rst_n = 1;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 rsp_valid after reset actual %0b expected 0", rsp_valid);
        end
        @(posedge clk); #1;
        drv_req(0, "R1");
        drv_req(1, "R2");
        drv_write(31'h7fff_ffff);
        drv_write(31'h0000_0001);
        drv_write(31'h2aaa_5555);
        drv_req(1, "R6");
        drv_req(1, "R6");
        drv_req(0, "R3");
        drv_req(0, "R3");
        drv_req(0, "R3");
        drv_req(0, "R2");
        drv_write(31'h0123_4567);
        q_enable = 0;
        drv_req(0, "R7");
        drv_req(1, "R7");
        q_enable = 1;
        drv_req(0, "R7");
        for (int i = 0; i < 40; i++) begin
            drv_write(31'h1000 + 31'(i));
            if (i % 7 == 3) drv_req(1, "R6");
            drv_req(0, "R4");
        end
        drv_req(0, "R5");
        for (int i = 0; i < DEPTH; i++) drv_write(31'h5000_0000 + 31'(i * 3 + 1));
        for (int i = 0; i < DEPTH; i++) drv_req(0, "R9");
        drv_req(0, "R5");
        drv_req(1, "R5");
        idle(3);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule